// File: doc/BRIEF.md
# Write Protection and Status Controller

This block guards the writes of a small serial memory that has 8K bytes by default. It holds the write enable latch and three protection bits: a two-bit block protection level and a hardware lock enable. From these bits and the level of the active-low write protect pin, it decides whether each array write or status write that the serial front end requests is allowed. The front end delivers decoded commands as single-cycle strobes. A status write carries a data byte and an array write carries an address.

When a write is allowed, the block pulses a grant and starts an internal write cycle of a fixed number of clocks, and busy is high for that whole cycle. The store itself is modelled only by this delay. New protection bits requested by a status write take effect at the end of the cycle, because in the real part they are nonvolatile cells. The write enable latch clears when a cycle ends, and it also clears when protection rejects a write. Software reads a status byte with this layout: bit 7 is the lock enable, bits 3:2 are the protection level, bit 1 is the write enable latch and bit 0 is busy. Bits 6:4 read 0. While a cycle runs, the whole byte reads 0xFF.

Top module: `wp_status_ctrl`

## Requirements
- R1: After a synchronous reset, status_byte is 0x00 and busy and write_grant are 0.
- R2: A set-enable strobe makes status bit 1 read 1 on the next cycle. A clear-enable strobe makes it read 0 on the next cycle, whatever the level of wp_n.
- R3: While the latch is 0, an array write or status write is refused: write_grant stays 0, busy stays 0 and the protection bits are unchanged.
- R4: With ADDR_W=13, protection level 00 protects no address, 01 protects 0x1800 to 0x1FFF, 10 protects 0x1000 to 0x1FFF and 11 protects every address. A write to a protected address is refused even when the latch is set.
- R5: When status bit 7 is 1 and wp_n is low, status writes are refused, so bit 7 cannot be cleared. Array writes to unprotected addresses are still granted.
- R6: A granted status write copies data bit 7 into status bit 7 and data bits 3:2 into status bits 3:2 when its cycle ends. All other data bits are ignored.
- R7: A granted write pulses write_grant for exactly one cycle, starting on the cycle after the strobe. busy is high for exactly CYCLE_CLKS cycles starting on that same cycle, and status_byte reads 0xFF for the whole time busy is high.
- R8: The latch reads 0 once a write cycle ends, and on the cycle after a write that protection refuses.
- R9: All strobes presented while busy is high have no effect.
- R10: When several strobes arrive in the same cycle, only one acts, in this order of priority: clear-enable, set-enable, status write, array write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wren | input | 1 | Set-enable strobe |
| cmd_wrdi | input | 1 | Clear-enable strobe |
| cmd_wrsr | input | 1 | Status write strobe |
| wrsr_data | input | 8 | Data byte that goes with a status write |
| cmd_write | input | 1 | Array write strobe |
| write_addr | input | ADDR_W | Address that goes with an array write |
| wp_n | input | 1 | Write protect pin, active low |
| status_byte | output | 8 | Status byte, registered |
| write_grant | output | 1 | One-cycle pulse when a write is accepted |
| busy | output | 1 | High while an internal write cycle runs |

## Verification
The assertions assume that strobes last one clock cycle each. They also assume that write_addr and wrsr_data are valid in the same cycle as their strobe, and that wp_n is a level that may change on any cycle. The stimulus drives every input away from the active clock edge. It holds each strobe for a single cycle, and it also fires strobes freely while busy is high and combines strobes in the same cycle, which makes the ignore and priority rules carry real load. A random phase toggles wp_n at any moment, including during a cycle. This shows that the lock is sampled only when a status write arrives.

// File: rtl/wpc_pkg.sv
package wpc_pkg;

  typedef enum logic [1:0] {
    PROT_NONE    = 2'b00,
    PROT_QUARTER = 2'b01,
    PROT_HALF    = 2'b10,
    PROT_ALL     = 2'b11
  } prot_lvl_e;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_CLR_WEL,
    OP_SET_WEL,
    OP_STATUS_WR,
    OP_ARRAY_WR
  } op_e;

  localparam int STAT_LOCK_BIT = 7;
  localparam int STAT_LVL_HI   = 3;
  localparam int STAT_LVL_LO   = 2;
  localparam int STAT_WEL_BIT  = 1;
  localparam int STAT_BUSY_BIT = 0;

  function automatic logic [7:0] pack_status(input logic in_cycle,
                                             input logic lock_en,
                                             input logic [1:0] lvl,
                                             input logic wel);
    logic [7:0] s;
    s = 8'h00;
    if (in_cycle) begin
      s = 8'hFF;
    end else begin
      s[STAT_LOCK_BIT] = lock_en;
      s[STAT_LVL_HI:STAT_LVL_LO] = lvl;
      s[STAT_WEL_BIT] = wel;
    end
    return s;
  endfunction

endpackage

// File: rtl/wpc_addr_guard.sv
module wpc_addr_guard
  import wpc_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  prot_lvl_e          lvl,
  input  logic [ADDR_W-1:0]  addr,
  output logic               hit
);
  localparam int TOP = ADDR_W - 1;

  always_comb begin
    unique case (lvl)
      PROT_NONE:    hit = 1'b0;
      PROT_QUARTER: hit = (addr[TOP -: 2] == 2'b11);
      PROT_HALF:    hit = addr[TOP];
      default:      hit = 1'b1;
    endcase
  end
endmodule

// File: rtl/wpc_cmd_select.sv
module wpc_cmd_select
  import wpc_pkg::*;
(
  input  logic cmd_wren,
  input  logic cmd_wrdi,
  input  logic cmd_wrsr,
  input  logic cmd_write,
  output op_e  op
);
  always_comb begin
    if (cmd_wrdi)       op = OP_CLR_WEL;
    else if (cmd_wren)  op = OP_SET_WEL;
    else if (cmd_wrsr)  op = OP_STATUS_WR;
    else if (cmd_write) op = OP_ARRAY_WR;
    else                op = OP_NONE;
  end
endmodule

// File: rtl/wpc_cycle_timer.sv
module wpc_cycle_timer #(
  parameter int CYCLE_CLKS = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CNT_W = (CYCLE_CLKS > 1) ? $clog2(CYCLE_CLKS) : 1;
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(CYCLE_CLKS - 1);

  logic [CNT_W-1:0] left_q;
  logic             busy_q;

  assign busy = busy_q;
  assign done = busy_q && (left_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      left_q <= '0;
    end else if (start && !busy_q) begin
      busy_q <= 1'b1;
      left_q <= LOAD;
    end else if (done) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      left_q <= left_q - 1'b1;
    end
  end
endmodule

// File: rtl/wp_status_ctrl.sv
module wp_status_ctrl
  import wpc_pkg::*;
#(
  parameter int ADDR_W     = 13,
  parameter int CYCLE_CLKS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_wren,
  input  logic              cmd_wrdi,
  input  logic              cmd_wrsr,
  input  logic [7:0]        wrsr_data,
  input  logic              cmd_write,
  input  logic [ADDR_W-1:0] write_addr,
  input  logic              wp_n,
  output logic [7:0]        status_byte,
  output logic              write_grant,
  output logic              busy
);
  op_e       op;
  logic      addr_hit;
  logic      tmr_busy, tmr_done;
  logic      hw_lock;

  logic      wel_q, wel_d;
  logic      lock_q, lock_d;
  prot_lvl_e lvl_q, lvl_d;
  logic      pend_sr_q;
  logic      pend_lock_q;
  prot_lvl_e pend_lvl_q;
  logic      grant_q;
  logic [7:0] status_q;

  logic      start, take_sr, busy_d;
  logic [7:0] status_d;

  wpc_cmd_select u_sel (
    .cmd_wren (cmd_wren),
    .cmd_wrdi (cmd_wrdi),
    .cmd_wrsr (cmd_wrsr),
    .cmd_write(cmd_write),
    .op       (op)
  );

  wpc_addr_guard #(.ADDR_W(ADDR_W)) u_guard (
    .lvl (lvl_q),
    .addr(write_addr),
    .hit (addr_hit)
  );

  wpc_cycle_timer #(.CYCLE_CLKS(CYCLE_CLKS)) u_tmr (
    .clk  (clk),
    .rst  (rst),
    .start(start),
    .busy (tmr_busy),
    .done (tmr_done)
  );

  assign hw_lock = lock_q && !wp_n;

  always_comb begin
    wel_d   = wel_q;
    lock_d  = lock_q;
    lvl_d   = lvl_q;
    start   = 1'b0;
    take_sr = 1'b0;
    if (tmr_done) begin
      wel_d = 1'b0;
      if (pend_sr_q) begin
        lock_d = pend_lock_q;
        lvl_d  = pend_lvl_q;
      end
    end else if (!tmr_busy) begin
      unique case (op)
        OP_CLR_WEL: wel_d = 1'b0;
        OP_SET_WEL: wel_d = 1'b1;
        OP_STATUS_WR: begin
          if (wel_q && !hw_lock) begin
            start   = 1'b1;
            take_sr = 1'b1;
          end else begin
            wel_d = 1'b0;
          end
        end
        OP_ARRAY_WR: begin
          if (wel_q && !addr_hit) start = 1'b1;
          else                    wel_d = 1'b0;
        end
        default: ;
      endcase
    end
    busy_d   = start || (tmr_busy && !tmr_done);
    status_d = pack_status(busy_d, lock_d, lvl_d, wel_d);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wel_q       <= 1'b0;
      lock_q      <= 1'b0;
      lvl_q       <= PROT_NONE;
      pend_sr_q   <= 1'b0;
      pend_lock_q <= 1'b0;
      pend_lvl_q  <= PROT_NONE;
      grant_q     <= 1'b0;
      status_q    <= 8'h00;
    end else begin
      wel_q    <= wel_d;
      lock_q   <= lock_d;
      lvl_q    <= lvl_d;
      grant_q  <= start;
      status_q <= status_d;
      if (start) begin
        pend_sr_q <= take_sr;
      end else if (tmr_done) begin
        pend_sr_q <= 1'b0;
      end
      if (take_sr) begin
        pend_lock_q <= wrsr_data[STAT_LOCK_BIT];
        pend_lvl_q  <= prot_lvl_e'(wrsr_data[STAT_LVL_HI:STAT_LVL_LO]);
      end
    end
  end

  assign status_byte = status_q;
  assign write_grant = grant_q;
  assign busy        = tmr_busy;
endmodule

// File: rtl/wpc_checker.sv
module wpc_checker #(
  parameter int CYCLE_CLKS = 8
) (
  input logic       clk,
  input logic       rst,
  input logic       cmd_wren,
  input logic       cmd_wrdi,
  input logic       cmd_wrsr,
  input logic       wp_n,
  input logic [7:0] status_byte,
  input logic       write_grant,
  input logic       busy
);
  int unsigned run_len;

  always_ff @(posedge clk) begin
    if (rst)       run_len <= 0;
    else if (busy) run_len <= run_len + 1;
    else           run_len <= 0;
  end

  assert_grant_needs_wen_R3: assert property (@(posedge clk) disable iff (rst)
    write_grant |-> ($past(status_byte[1]) && !$past(busy)));

  assert_grant_starts_busy_R7: assert property (@(posedge clk) disable iff (rst)
    write_grant |-> busy);

  assert_busy_reads_ff_R7: assert property (@(posedge clk) disable iff (rst)
    busy |-> (status_byte == 8'hFF));

  assert_busy_len_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (run_len == CYCLE_CLKS));

  assert_busy_not_long_R7: assert property (@(posedge clk) disable iff (rst)
    busy |-> (run_len < CYCLE_CLKS));

  assert_wen_clear_after_cycle_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> !status_byte[1]);

  assert_idle_fields_R1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (status_byte[6:4] == 3'b000 && !status_byte[0]));

  assert_lock_blocks_status_R5: assert property (@(posedge clk) disable iff (rst)
    (cmd_wrsr && !cmd_wren && !cmd_wrdi && !busy && status_byte[7] && !wp_n)
      |=> !write_grant);
endmodule

bind wp_status_ctrl wpc_checker #(.CYCLE_CLKS(CYCLE_CLKS)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cmd_wren   (cmd_wren),
  .cmd_wrdi   (cmd_wrdi),
  .cmd_wrsr   (cmd_wrsr),
  .wp_n       (wp_n),
  .status_byte(status_byte),
  .write_grant(write_grant),
  .busy       (busy)
);

// File: tb/tb_wp_status_ctrl.sv
`timescale 1ns/1ps
module tb_wp_status_ctrl;
  localparam int AW  = 13;
  localparam int CYC = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_wren = 0, cmd_wrdi = 0, cmd_wrsr = 0, cmd_write = 0;
  logic [7:0] wrsr_data = 8'h00;
  logic [AW-1:0] write_addr = '0;
  logic wp_n = 1'b1;
  logic [7:0] status_byte;
  logic write_grant, busy;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // reference model state
  int m_wen = 0, m_bp = 0, m_lock = 0, m_left = 0, m_busy = 0, m_grant = 0;
  int m_pend = 0, m_pbp = 0, m_plock = 0;

  always #4 clk = ~clk;

  wp_status_ctrl #(.ADDR_W(AW), .CYCLE_CLKS(CYC)) dut (
    .clk(clk), .rst(rst), .cmd_wren(cmd_wren), .cmd_wrdi(cmd_wrdi),
    .cmd_wrsr(cmd_wrsr), .wrsr_data(wrsr_data), .cmd_write(cmd_write),
    .write_addr(write_addr), .wp_n(wp_n), .status_byte(status_byte),
    .write_grant(write_grant), .busy(busy)
  );

  function automatic int prot_hit(int lvl, int a);
    if (lvl == 0) return 0;
    if (lvl == 1) return (a >= 'h1800) ? 1 : 0;
    if (lvl == 2) return (a >= 'h1000) ? 1 : 0;
    return 1;
  endfunction

  function automatic logic [7:0] exp_status();
    if (m_busy != 0) return 8'hFF;
    return {m_lock[0], 3'b000, m_bp[1:0], m_wen[0], 1'b0};
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      m_wen = 0; m_bp = 0; m_lock = 0; m_left = 0; m_busy = 0;
      m_grant = 0; m_pend = 0;
    end else begin
      m_grant = 0;
      if (m_busy != 0) begin
        m_left--;
        if (m_left == 0) begin
          m_busy = 0; m_wen = 0;
          if (m_pend != 0) begin m_bp = m_pbp; m_lock = m_plock; end
          m_pend = 0;
        end
      end else if (cmd_wrdi) m_wen = 0;
      else if (cmd_wren) m_wen = 1;
      else if (cmd_wrsr) begin
        if (m_wen != 0 && !(m_lock != 0 && !wp_n)) begin
          m_busy = 1; m_left = CYC; m_grant = 1; m_pend = 1;
          m_pbp = int'(wrsr_data[3:2]); m_plock = int'(wrsr_data[7]);
        end else m_wen = 0;
      end else if (cmd_write) begin
        if (m_wen != 0 && prot_hit(m_bp, int'(write_addr)) == 0) begin
          m_busy = 1; m_left = CYC; m_grant = 1; m_pend = 0;
        end else m_wen = 0;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      check(busy == m_busy[0], "R7 busy", busy, m_busy);
      check(write_grant == m_grant[0], "R7 grant", write_grant, m_grant);
      check(status_byte == exp_status(), "R8 status", status_byte, exp_status());
    end
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cycles == 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected below %0d", cycles, 100000);
      finish_run();
    end
  end

  task automatic clear_strobes();
    cmd_wren = 0; cmd_wrdi = 0; cmd_wrsr = 0; cmd_write = 0;
  endtask

  // strobes set at a negedge, cleared at the next; returns at that negedge
  task automatic pulse(input bit wr_en, input bit wr_di, input bit sr, input bit wr,
                       input logic [7:0] d, input int a);
    @(negedge clk);
    cmd_wren = wr_en; cmd_wrdi = wr_di; cmd_wrsr = sr; cmd_write = wr;
    wrsr_data = d; write_addr = AW'(a);
    @(negedge clk);
    clear_strobes();
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic set_wen();  pulse(1, 0, 0, 0, 8'h00, 0); endtask
  task automatic wr_arr(input int a); pulse(0, 0, 0, 1, 8'h00, a); endtask
  task automatic wr_sr(input logic [7:0] d); pulse(0, 0, 1, 0, d, 0); endtask

  task automatic set_prot(input logic [7:0] d);
    wp_n = 1'b1;
    set_wen(); wr_sr(d); wait_idle();
  endtask

  task automatic try_addr(input int a, input bit expect_grant, input string req);
    set_wen(); wr_arr(a);
    check(write_grant == expect_grant, req, write_grant, expect_grant);
    wait_idle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(status_byte == 8'h00 && !busy && !write_grant, "R1 reset", status_byte, 0);
    rst = 1'b0;
    @(negedge clk);
    check(status_byte == 8'h00, "R1 after reset", status_byte, 0);

    set_wen();
    check(status_byte == 8'h02, "R2 set enable", status_byte, 8'h02);
    wp_n = 1'b0;
    pulse(0, 1, 0, 0, 8'h00, 0);
    check(status_byte == 8'h00, "R2 clear with pin low", status_byte, 0);
    wp_n = 1'b1;

    wr_arr('h0010);
    check(!write_grant && !busy, "R3 array write without enable", busy, 0);
    wr_sr(8'h8C);
    check(!write_grant && status_byte == 8'h00, "R3 status write without enable", status_byte, 0);

    set_wen(); wr_sr(8'hFC);
    check(write_grant == 1'b1, "R7 grant pulse", write_grant, 1);
    check(status_byte == 8'hFF, "R7 status during cycle", status_byte, 8'hFF);
    @(negedge clk);
    check(write_grant == 1'b0, "R7 grant single cycle", write_grant, 0);
    wait_idle();
    check(status_byte == 8'h8C, "R6 fields updated, R8 enable cleared", status_byte, 8'h8C);

    // level 01
    set_prot(8'h04);
    try_addr('h17FF, 1, "R4 quarter below");
    try_addr('h1800, 0, "R4 quarter edge");
    check(status_byte[1] == 1'b0, "R8 cleared on refusal", status_byte, 0);
    // level 10
    set_prot(8'h08);
    try_addr('h0FFF, 1, "R4 half below");
    try_addr('h1000, 0, "R4 half edge");
    // level 11
    set_prot(8'h0C);
    try_addr('h0000, 0, "R4 all low");
    // level 00
    set_prot(8'h00);
    try_addr('h1FFF, 1, "R4 none top");

    // hardware lock
    set_prot(8'h80);
    wp_n = 1'b0;
    set_wen(); wr_sr(8'h00);
    check(!write_grant && status_byte == 8'h80, "R5 status locked", status_byte, 8'h80);
    try_addr('h0010, 1, "R5 array allowed under lock");
    wp_n = 1'b1;
    set_wen(); wr_sr(8'h00); wait_idle();
    check(status_byte == 8'h00, "R5 unlock after pin high", status_byte, 0);

    // strobes during busy
    set_wen(); wr_arr('h0020);
    pulse(1, 0, 0, 0, 8'h00, 0);
    pulse(0, 0, 1, 0, 8'h0C, 0);
    wait_idle();
    check(status_byte == 8'h00, "R9 strobes ignored while busy", status_byte, 0);

    // priorities
    pulse(1, 1, 0, 0, 8'h00, 0);
    check(status_byte == 8'h00, "R10 clear beats set", status_byte, 0);
    pulse(1, 0, 1, 1, 8'h0C, 'h10);
    check(!write_grant && status_byte == 8'h02, "R10 set beats writes", status_byte, 8'h02);
    pulse(0, 0, 1, 1, 8'h04, 'h10);
    wait_idle();
    check(status_byte == 8'h04, "R10 status write beats array write", status_byte, 8'h04);

    // random phase, model comparison every cycle
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      cmd_wren  = ($urandom_range(0, 3) == 0);
      cmd_wrdi  = ($urandom_range(0, 15) == 0);
      cmd_wrsr  = ($urandom_range(0, 5) == 0);
      cmd_write = ($urandom_range(0, 3) == 0);
      wrsr_data = 8'($urandom);
      write_addr = AW'($urandom);
      if ($urandom_range(0, 9) == 0) wp_n = ~wp_n;
    end
    @(negedge clk);
    clear_strobes();
    repeat (CYC + 2) @(negedge clk);
    finish_run();
  end
endmodule